// File: doc/BRIEF.md
# Multi-Size Translation Lookaside Buffer

This block is a fully associative table of translation entries that turns a 32-bit virtual address into a physical address. It can also report the reason a translation fails. Software fills the table through an indexed write port. Each entry carries these fields:

- a valid flag and a shared flag
- an 8-bit address-space tag
- a virtual page number (address bits 31:10) and a physical page number
- a page-size code
- a two-bit permission field
- a dirty flag

A lookup presents the following inputs:

- the address
- the access kind (read, write or instruction fetch)
- the privilege level
- a flag that relaxes tag checking for privileged code
- the current address-space tag

One cycle later the block reports either the translated address or a three-bit fault code. A free-running replacement counter advances on every lookup. It wraps at a software-set bound, and the refill logic outside this block uses it to pick a victim slot. One input pulse clears every valid flag at once.

Top module: `tlbx_top`

## Requirements
- R1: A write with `wr_en` high loads all fields of slot `wr_idx`. A lookup issued in any later cycle sees the new contents. A slot loaded with `wr_valid` low never matches.
- R2: The size code selects the page size: 0 = 1 KB, 1 = 4 KB, 2 = 64 KB, 3 = 1 MB. Virtual page number bits below the page size are ignored in the compare. Addresses just beyond the page end miss.
- R3: The address-space tag is compared when `lk_sv` = 0 or when `lk_priv` = 0. A privileged lookup with `lk_sv` = 1 ignores the tag. An entry whose shared flag is set matches any tag.
- R4: Fault codes are reported on `rsp_fault`:
  - two or more matching valid entries give code 3 (multiple hit)
  - no match gives code 1 for a read or fetch, and code 2 for a write
  - a fetch is checked exactly like a read
- R5: The permission field (bit 1, bit 0) works as follows:
  - privileged code may always read, and may write only when bit 0 is 1
  - user code may read only when bit 1 is 1, and may write only when the field is 3
  - a refused read or fetch gives code 4, and a refused write gives code 5
- R6: A write that the permission check allows, to an entry whose dirty flag is 0, gives code 6.
- R7: On success (code 0), the physical address is built from three parts:
  - the physical page bits above the page size
  - the virtual page bits below the page size
  - the 10-bit offset, unchanged
- R8: `urc` increases by one on every lookup. The result is forced to 0 if it would exceed a nonzero `urb`, or if it would exceed the last slot index. Without a lookup it holds.
- R9: `rsp_valid` is high exactly in the cycle after a cycle with `lk_req` high. When `rsp_valid` is low, `rsp_fault` and `rsp_paddr` are 0. `rsp_paddr` is also 0 for any nonzero fault.
- R10: `invalidate` clears every valid flag in one cycle and wins over a write in the same cycle, which is dropped. A lookup in the same cycle as a write or an invalidate sees the table as it was before that cycle.
- R11: After reset the following hold:
  - every slot is invalid
  - `urc` is 0
  - `rsp_valid`, `rsp_fault` and `rsp_paddr` are 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| invalidate | input | 1 | Clear all valid flags |
| wr_en | input | 1 | Load slot `wr_idx` |
| wr_idx | input | 6 | Slot to load |
| wr_valid | input | 1 | Valid flag to store |
| wr_shared | input | 1 | Shared flag to store |
| wr_asid | input | 8 | Address-space tag to store |
| wr_vpn | input | 22 | Virtual page number to store |
| wr_ppn | input | 22 | Physical page number to store |
| wr_size | input | 2 | Page-size code to store |
| wr_prot | input | 2 | Permission field to store |
| wr_dirty | input | 1 | Dirty flag to store |
| lk_req | input | 1 | Start a lookup |
| lk_vaddr | input | 32 | Virtual address |
| lk_kind | input | 2 | 0 read, 1 write, 2 fetch |
| lk_priv | input | 1 | 1 = privileged access |
| lk_sv | input | 1 | Relax tag check for privileged code |
| lk_asid | input | 8 | Current address-space tag |
| urb | input | 6 | Replacement counter bound (0 = none) |
| rsp_valid | output | 1 | Lookup result present |
| rsp_fault | output | 3 | Fault code, 0 = success |
| rsp_paddr | output | 32 | Translated address |
| urc | output | 6 | Replacement counter |

## Verification
The assertions assume that no input is unknown once reset is released. They also assume that `invalidate` is low during the first cycle after reset, because the flush check looks one cycle back at it. The bench drives every input to a defined value from time zero, keeps `invalidate` low except in its directed flush steps, and changes inputs only on the falling edge. The table vectors all run against a fixed set of loaded slots. Every address in them lies inside exactly one loaded page, straddles a page edge, or falls in the deliberately duplicated slot pair, so each expected code follows from a single rule.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    localparam int VA_W     = 32;
    localparam int OFF_W    = 10;
    localparam int VPN_W    = VA_W - OFF_W;
    localparam int TAG_W    = 8;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        FLT_OK     = 3'd0,
        FLT_RMISS  = 3'd1,
        FLT_WMISS  = 3'd2,
        FLT_MULTI  = 3'd3,
        FLT_RVIOL  = 3'd4,
        FLT_WVIOL  = 3'd5,
        FLT_INITW  = 3'd6
    } fault_e;

    typedef enum logic {
        RSP_IDLE = 1'b0,
        RSP_DONE = 1'b1
    } rsp_state_e;

    typedef struct packed {
        logic             valid;
        logic             shared;
        logic [TAG_W-1:0] asid;
        logic [VPN_W-1:0] vpn;
        logic [VPN_W-1:0] ppn;
        logic [1:0]       size;
        logic [1:0]       prot;
        logic             dirty;
    } entry_t;

    // Page-number bits that lie inside the page for a given size code (R2).
    function automatic logic [VPN_W-1:0] page_mask(input logic [1:0] sz);
        logic [VPN_W-1:0] m;
        unique case (sz)
            2'd0:    m = '0;
            2'd1:    m = VPN_W'(22'h3);
            2'd2:    m = VPN_W'(22'h3F);
            default: m = VPN_W'(22'h3FF);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tlbx_store.sv
module tlbx_store
    import tlbx_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             invalidate,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  entry_t           wr_entry,
    output entry_t           ents [N_ENTRIES]
);

    entry_t ents_q [N_ENTRIES];

    // R10: flush beats load; R11: reset leaves every slot invalid.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                ents_q[i] <= '0;
            end
        end else if (invalidate) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                ents_q[i].valid <= 1'b0;
            end
        end else if (wr_en) begin
            ents_q[wr_idx] <= wr_entry;
        end
    end

    assign ents = ents_q;

endmodule

// File: rtl/tlbx_match.sv
module tlbx_match
    import tlbx_pkg::*;
#(
    parameter int N_ENTRIES = 64
) (
    input  entry_t           ents [N_ENTRIES],
    input  logic [VPN_W-1:0] vpn,
    input  logic             use_asid,
    input  logic [TAG_W-1:0] asid,
    output logic             hit_any,
    output logic             hit_multi,
    output logic [VPN_W-1:0] sel_ppn,
    output logic [1:0]       sel_size,
    output logic [1:0]       sel_prot,
    output logic             sel_dirty
);

    logic [N_ENTRIES-1:0] hits;

    // One comparator per slot (R2, R3).
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
        logic tag_ok;
        logic page_ok;
        assign tag_ok  = !use_asid || ents[g].shared || (ents[g].asid == asid);
        assign page_ok = ((ents[g].vpn ^ vpn) & ~page_mask(ents[g].size)) == '0;
        assign hits[g] = ents[g].valid && tag_ok && page_ok;
    end

    // More than one bit set: clearing the lowest set bit leaves something (R4).
    assign hit_any   = |hits;
    assign hit_multi = |(hits & (hits - N_ENTRIES'(1)));

    always_comb begin
        sel_ppn   = '0;
        sel_size  = '0;
        sel_prot  = '0;
        sel_dirty = 1'b0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            sel_ppn   = sel_ppn   | ({VPN_W{hits[i]}} & ents[i].ppn);
            sel_size  = sel_size  | ({2{hits[i]}} & ents[i].size);
            sel_prot  = sel_prot  | ({2{hits[i]}} & ents[i].prot);
            sel_dirty = sel_dirty | (hits[i] & ents[i].dirty);
        end
    end

endmodule

// File: rtl/tlbx_perm.sv
module tlbx_perm
    import tlbx_pkg::*;
(
    input  logic             hit_any,
    input  logic             hit_multi,
    input  logic [VPN_W-1:0] ppn,
    input  logic [1:0]       size,
    input  logic [1:0]       prot,
    input  logic             dirty,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [1:0]       kind,
    input  logic             priv,
    output fault_e           fault,
    output logic [VA_W-1:0]  paddr
);

    logic             is_wr;
    logic             rd_ok;
    logic             wr_ok;
    logic [VPN_W-1:0] low;

    assign is_wr = (kind == ACC_WRITE);
    // R5: privileged reads always pass; user reads need bit 1.
    assign rd_ok = priv | prot[1];
    assign wr_ok = priv ? prot[0] : (prot == 2'b11);
    assign low   = page_mask(size);

    always_comb begin
        if (hit_multi) begin
            fault = FLT_MULTI;
        end else if (!hit_any) begin
            fault = is_wr ? FLT_WMISS : FLT_RMISS;
        end else if (is_wr) begin
            if (!wr_ok)      fault = FLT_WVIOL;
            else if (!dirty) fault = FLT_INITW;
            else             fault = FLT_OK;
        end else begin
            fault = rd_ok ? FLT_OK : FLT_RVIOL;
        end
    end

    // R7: page bits from the entry above the size, from the address below it.
    always_comb begin
        if (fault == FLT_OK) begin
            paddr = {(ppn & ~low) | (vaddr[VA_W-1:OFF_W] & low), vaddr[OFF_W-1:0]};
        end else begin
            paddr = '0;
        end
    end

endmodule

// File: rtl/tlbx_urc.sv
module tlbx_urc #(
    parameter int N_ENTRIES = 64,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [IDX_W-1:0] urb,
    output logic [IDX_W-1:0] urc
);

    localparam logic [IDX_W:0] LAST = (IDX_W+1)'(N_ENTRIES - 1);

    logic [IDX_W-1:0] urc_q;
    logic [IDX_W:0]   inc;
    logic             wrap;

    assign inc  = {1'b0, urc_q} + (IDX_W+1)'(1);
    assign wrap = ((urb != '0) && (inc > {1'b0, urb})) || (inc > LAST);

    // R8
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            urc_q <= '0;
        end else if (step) begin
            urc_q <= wrap ? '0 : inc[IDX_W-1:0];
        end
    end

    assign urc = urc_q;

endmodule

// File: rtl/tlbx_top.sv
module tlbx_top
    import tlbx_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             invalidate,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic             wr_shared,
    input  logic [7:0]       wr_asid,
    input  logic [21:0]      wr_vpn,
    input  logic [21:0]      wr_ppn,
    input  logic [1:0]       wr_size,
    input  logic [1:0]       wr_prot,
    input  logic             wr_dirty,
    input  logic             lk_req,
    input  logic [31:0]      lk_vaddr,
    input  logic [1:0]       lk_kind,
    input  logic             lk_priv,
    input  logic             lk_sv,
    input  logic [7:0]       lk_asid,
    input  logic [IDX_W-1:0] urb,
    output logic             rsp_valid,
    output logic [2:0]       rsp_fault,
    output logic [31:0]      rsp_paddr,
    output logic [IDX_W-1:0] urc
);

    entry_t           wr_entry;
    entry_t           ents [N_ENTRIES];
    logic             use_asid;
    logic             hit_any;
    logic             hit_multi;
    logic [VPN_W-1:0] sel_ppn;
    logic [1:0]       sel_size;
    logic [1:0]       sel_prot;
    logic             sel_dirty;
    fault_e           fault;
    logic [VA_W-1:0]  paddr;

    rsp_state_e       state_q;
    rsp_state_e       state_d;
    logic [2:0]       fault_q;
    logic [31:0]      paddr_q;

    assign wr_entry = '{valid: wr_valid, shared: wr_shared, asid: wr_asid,
                        vpn: wr_vpn, ppn: wr_ppn, size: wr_size,
                        prot: wr_prot, dirty: wr_dirty};

    // R3
    assign use_asid = !lk_sv || !lk_priv;

    tlbx_store #(.N_ENTRIES(N_ENTRIES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .invalidate (invalidate),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_entry   (wr_entry),
        .ents       (ents)
    );

    tlbx_match #(.N_ENTRIES(N_ENTRIES)) u_match (
        .ents      (ents),
        .vpn       (lk_vaddr[VA_W-1:OFF_W]),
        .use_asid  (use_asid),
        .asid      (lk_asid),
        .hit_any   (hit_any),
        .hit_multi (hit_multi),
        .sel_ppn   (sel_ppn),
        .sel_size  (sel_size),
        .sel_prot  (sel_prot),
        .sel_dirty (sel_dirty)
    );

    tlbx_perm u_perm (
        .hit_any   (hit_any),
        .hit_multi (hit_multi),
        .ppn       (sel_ppn),
        .size      (sel_size),
        .prot      (sel_prot),
        .dirty     (sel_dirty),
        .vaddr     (lk_vaddr),
        .kind      (lk_kind),
        .priv      (lk_priv),
        .fault     (fault),
        .paddr     (paddr)
    );

    tlbx_urc #(.N_ENTRIES(N_ENTRIES)) u_urc (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (lk_req),
        .urb   (urb),
        .urc   (urc)
    );

    // Response sequencer: RSP_IDLE -> RSP_DONE on a request (R9).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_IDLE: state_d = lk_req ? RSP_DONE : RSP_IDLE;
            RSP_DONE: state_d = lk_req ? RSP_DONE : RSP_IDLE;
            default:  state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: captures the result only for a request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= '0;
            paddr_q <= '0;
        end else if (lk_req) begin
            fault_q <= fault;
            paddr_q <= paddr;
        end else begin
            fault_q <= '0;
            paddr_q <= '0;
        end
    end

    assign rsp_valid = (state_q == RSP_DONE);
    assign rsp_fault = fault_q;
    assign rsp_paddr = paddr_q;

endmodule

// File: rtl/tlbx_chk.sv
module tlbx_chk #(
    parameter int N_ENTRIES = 64,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             invalidate,
    input logic             lk_req,
    input logic [IDX_W-1:0] urb,
    input logic             rsp_valid,
    input logic [2:0]       rsp_fault,
    input logic [31:0]      rsp_paddr,
    input logic [IDX_W-1:0] urc
);

    a_r9_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);

    a_r9_no_req_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_fault == 3'd0 && rsp_paddr == 32'd0));

    a_r9_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'd0) |-> rsp_paddr == 32'd0);

    a_r4_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_fault <= 3'd6);

    a_r8_urc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> $stable(urc));

    a_r8_urc_bound_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && urb != '0 && urc >= urb) |=> urc == '0);

    a_r10_empty_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(invalidate) && lk_req) |=> (rsp_fault == 3'd1 || rsp_fault == 3'd2));

endmodule

bind tlbx_top tlbx_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (.*);

// File: tb/tb_tlbx_top.sv
`timescale 1ns/1ps
module tb_tlbx_top;

    typedef struct packed {
        logic [3:0]  tag;
        logic [1:0]  kind;
        logic        priv;
        logic        sv;
        logic [7:0]  asid;
        logic [31:0] va;
        logic [2:0]  fault;
        logic [31:0] pa;
    } vec_t;

    // tag = requirement number; kind 0 read, 1 write, 2 fetch
    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{4'd7, 2'd0, 1'b1, 1'b0, 8'd5, 32'h0000_1234, 3'd0, 32'h1000_0234}, // R7 1K
        '{4'd5, 2'd1, 1'b0, 1'b0, 8'd5, 32'h0000_1234, 3'd0, 32'h1000_0234}, // R5 user rw
        '{4'd3, 2'd0, 1'b0, 1'b0, 8'd6, 32'h0000_1234, 3'd1, 32'h0},         // R3 tag mismatch
        '{4'd3, 2'd0, 1'b0, 1'b1, 8'd6, 32'h0000_1234, 3'd1, 32'h0},         // R3 sv no help in user
        '{4'd2, 2'd0, 1'b0, 1'b0, 8'd5, 32'h0001_0ABC, 3'd0, 32'h2000_0ABC}, // R2 4K, shared
        '{4'd5, 2'd1, 1'b0, 1'b0, 8'd5, 32'h0001_0ABC, 3'd5, 32'h0},         // R5 read-only
        '{4'd4, 2'd2, 1'b0, 1'b0, 8'd5, 32'h0001_0FFF, 3'd0, 32'h2000_0FFF}, // R4 fetch as read
        '{4'd6, 2'd1, 1'b1, 1'b0, 8'd5, 32'h0040_1234, 3'd6, 32'h0},         // R6 clean page
        '{4'd2, 2'd0, 1'b1, 1'b0, 8'd5, 32'h0040_FFFC, 3'd0, 32'h0004_FFFC}, // R2 64K
        '{4'd5, 2'd0, 1'b0, 1'b0, 8'd5, 32'h0040_1234, 3'd4, 32'h0},         // R5 priv-only
        '{4'd3, 2'd0, 1'b1, 1'b0, 8'd7, 32'h0040_1234, 3'd1, 32'h0},         // R3 tag checked
        '{4'd3, 2'd0, 1'b1, 1'b1, 8'd7, 32'h0040_1234, 3'd0, 32'h0004_1234}, // R3 sv bypass
        '{4'd2, 2'd0, 1'b1, 1'b0, 8'd0, 32'h010A_BCDE, 3'd0, 32'h040A_BCDE}, // R2 1M
        '{4'd5, 2'd1, 1'b1, 1'b0, 8'd0, 32'h010A_BCDE, 3'd5, 32'h0},         // R5 prot 0 write
        '{4'd5, 2'd0, 1'b0, 1'b0, 8'd0, 32'h010A_BCDE, 3'd4, 32'h0},         // R5 prot 0 user
        '{4'd4, 2'd2, 1'b1, 1'b0, 8'd0, 32'h0100_0000, 3'd0, 32'h0400_0000}, // R4 fetch ok
        '{4'd4, 2'd0, 1'b1, 1'b0, 8'd0, 32'h0800_0100, 3'd3, 32'h0},         // R4 multi
        '{4'd4, 2'd1, 1'b1, 1'b0, 8'd0, 32'h3000_0000, 3'd2, 32'h0},         // R4 write miss
        '{4'd4, 2'd2, 1'b0, 1'b0, 8'd0, 32'h3000_0000, 3'd1, 32'h0},         // R4 fetch miss
        '{4'd1, 2'd0, 1'b1, 1'b0, 8'd0, 32'h0500_0000, 3'd1, 32'h0},         // R1 invalid slot
        '{4'd2, 2'd0, 1'b1, 1'b0, 8'd5, 32'h0000_1400, 3'd1, 32'h0},         // R2 1K edge
        '{4'd2, 2'd0, 1'b1, 1'b0, 8'd5, 32'h0001_1000, 3'd1, 32'h0},         // R2 4K edge
        '{4'd2, 2'd0, 1'b1, 1'b0, 8'd5, 32'h0041_0000, 3'd1, 32'h0},         // R2 64K edge
        '{4'd2, 2'd0, 1'b1, 1'b0, 8'd0, 32'h0110_0000, 3'd1, 32'h0},         // R2 1M edge
        '{4'd5, 2'd1, 1'b1, 1'b0, 8'd5, 32'h0000_1000, 3'd0, 32'h1000_0000}, // R5 priv write
        '{4'd4, 2'd2, 1'b0, 1'b0, 8'd5, 32'h0040_1234, 3'd4, 32'h0}          // R4 fetch viol
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        invalidate = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic        wr_valid = 1'b0;
    logic        wr_shared = 1'b0;
    logic [7:0]  wr_asid = '0;
    logic [21:0] wr_vpn = '0;
    logic [21:0] wr_ppn = '0;
    logic [1:0]  wr_size = '0;
    logic [1:0]  wr_prot = '0;
    logic        wr_dirty = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_kind = '0;
    logic        lk_priv = 1'b0;
    logic        lk_sv = 1'b0;
    logic [7:0]  lk_asid = '0;
    logic [5:0]  urb = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_fault;
    logic [31:0] rsp_paddr;
    logic [5:0]  urc;

    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [5:0]  exp_urc = '0;

    always #2.5 clk = ~clk;

    tlbx_top dut (.*);

    function automatic logic [5:0] urc_next(input logic [5:0] cur, input logic [5:0] bnd);
        int n = int'(cur) + 1;
        if ((bnd != 0 && n > int'(bnd)) || n > 63) n = 0;
        return 6'(n);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic stage_load(input int idx, input logic v, input logic sh, input logic [7:0] a,
                              input logic [21:0] vp, input logic [21:0] pp,
                              input logic [1:0] sz, input logic [1:0] pr, input logic d);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_valid = v; wr_shared = sh; wr_asid = a;
        wr_vpn = vp; wr_ppn = pp; wr_size = sz; wr_prot = pr; wr_dirty = d;
    endtask

    task automatic load(input int idx, input logic v, input logic sh, input logic [7:0] a,
                        input logic [21:0] vp, input logic [21:0] pp,
                        input logic [1:0] sz, input logic [1:0] pr, input logic d);
        stage_load(idx, v, sh, a, vp, pp, sz, pr, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Called just after a falling edge; returns after the result is registered.
    task automatic lookup(input logic [1:0] k, input logic p, input logic s,
                          input logic [7:0] a, input logic [31:0] va);
        lk_req = 1'b1; lk_kind = k; lk_priv = p; lk_sv = s; lk_asid = a; lk_vaddr = va;
        @(negedge clk);
        lk_req = 1'b0; wr_en = 1'b0; invalidate = 1'b0;
        exp_urc = urc_next(exp_urc, urb);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 valid in reset", 32'(rsp_valid), 32'd0);
        check("R11 urc in reset", 32'(urc), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 fault after reset", 32'(rsp_fault), 32'd0);
        check("R11 paddr after reset", 32'(rsp_paddr), 32'd0);
        lookup(2'd0, 1'b1, 1'b1, 8'd0, 32'h0000_1234);
        check("R11 empty table miss", 32'(rsp_fault), 32'd1);
        check("R9 valid after req", 32'(rsp_valid), 32'd1);

        load(0,  1'b1, 1'b0, 8'd5, 22'h00004, 22'h40000, 2'd0, 2'd3, 1'b1);
        load(1,  1'b1, 1'b1, 8'd9, 22'h00043, 22'h80003, 2'd1, 2'd2, 1'b1);
        load(2,  1'b1, 1'b0, 8'd5, 22'h01000, 22'h00100, 2'd2, 2'd1, 1'b0);
        load(3,  1'b1, 1'b1, 8'd0, 22'h04000, 22'h10000, 2'd3, 2'd0, 1'b1);
        load(5,  1'b0, 1'b0, 8'd0, 22'h14000, 22'h3FFFF, 2'd0, 2'd3, 1'b1);
        load(10, 1'b1, 1'b1, 8'd0, 22'h20000, 22'h00001, 2'd0, 2'd3, 1'b1);
        load(11, 1'b1, 1'b1, 8'd3, 22'h20000, 22'h00002, 2'd0, 2'd3, 1'b1);

        for (int i = 0; i < NV; i++) begin
            lookup(VECS[i].kind, VECS[i].priv, VECS[i].sv, VECS[i].asid, VECS[i].va);
            check($sformatf("R%0d vec %0d valid", VECS[i].tag, i), 32'(rsp_valid), 32'd1);
            check($sformatf("R%0d vec %0d fault", VECS[i].tag, i), 32'(rsp_fault), 32'(VECS[i].fault));
            check($sformatf("R%0d vec %0d paddr", VECS[i].tag, i), rsp_paddr, VECS[i].pa);
        end

        // R9: idle cycle drops valid and clears outputs
        @(negedge clk);
        check("R9 idle valid", 32'(rsp_valid), 32'd0);
        check("R9 idle fault", 32'(rsp_fault), 32'd0);
        check("R9 idle paddr", 32'(rsp_paddr), 32'd0);

        // R8: counter model, bounded then unbounded
        check("R8 urc count", 32'(urc), 32'(exp_urc));
        urb = 6'd2;
        for (int i = 0; i < 4; i++) begin
            lookup(2'd0, 1'b1, 1'b0, 8'd5, 32'h0000_1234);
            check($sformatf("R8 bounded step %0d", i), 32'(urc), 32'(exp_urc));
        end
        urb = 6'd0;
        for (int i = 0; i < 70; i++) begin
            lookup(2'd0, 1'b1, 1'b0, 8'd5, 32'h0000_1234);
        end
        check("R8 unbounded wrap", 32'(urc), 32'(exp_urc));

        // R10/R1: lookup in the cycle of a rewrite sees the old slot
        stage_load(0, 1'b1, 1'b0, 8'd5, 22'h00004, 22'h12345, 2'd0, 2'd3, 1'b1);
        lookup(2'd0, 1'b1, 1'b0, 8'd5, 32'h0000_1234);
        check("R10 same-cycle write old", rsp_paddr, 32'h1000_0234);
        lookup(2'd0, 1'b1, 1'b0, 8'd5, 32'h0000_1234);
        check("R1 rewrite visible", rsp_paddr, 32'h048D_1634);

        // R10: flush sees old table in its own cycle, empty afterwards
        invalidate = 1'b1;
        lookup(2'd0, 1'b1, 1'b0, 8'd5, 32'h0000_1234);
        check("R10 flush-cycle lookup old", rsp_paddr, 32'h048D_1634);
        lookup(2'd0, 1'b1, 1'b0, 8'd5, 32'h0001_0ABC);
        check("R10 after flush miss", 32'(rsp_fault), 32'd1);

        // R10: load together with flush is dropped
        stage_load(0, 1'b1, 1'b0, 8'd5, 22'h00004, 22'h40000, 2'd0, 2'd3, 1'b1);
        invalidate = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; invalidate = 1'b0;
        lookup(2'd0, 1'b1, 1'b0, 8'd5, 32'h0000_1234);
        check("R10 write dropped by flush", 32'(rsp_fault), 32'd1);

        // R1: normal load afterwards works
        load(0, 1'b1, 1'b0, 8'd5, 22'h00004, 22'h40000, 2'd0, 2'd3, 1'b1);
        lookup(2'd0, 1'b1, 1'b0, 8'd5, 32'h0000_1234);
        check("R1 reload hit", rsp_paddr, 32'h1000_0234);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule